// File: doc/BRIEF.md
# Isochronous 1x-Clock UART Datapath

This block pairs a UART transmitter with a UART receiver. Each side runs either in the usual oversampled mode, driven by an internal divider, or in a 1x isochronous mode. In the 1x mode every serial bit occupies exactly one period of a supplied bit clock, and the start, optional parity and stop framing of an asynchronous character is kept. The transmit bit clock and the receive bit clock arrive on separate inputs. The block samples them as level signals in the system clock domain and turns each rising edge into a one-cycle enable.

An 8-bit clock-select register chooses the mode of each direction on its own. The transmitter takes bytes through a ready/valid handshake. The receiver presents each character with a one-cycle valid pulse, together with framing and parity flags. The internal divider's bit-rate clock is driven out as a square wave, so that a remote end can use it as its 1x clock. A masked change detector watches the two bit-clock inputs. When a clock toggles on one of those inputs, the mask keeps the detector from firing continuously.

Top module: `iso_uart_core`

## Requirements
- R1: Clock-select bit 7 set puts the transmitter in 1x mode and bit 3 set puts the receiver in 1x mode, each independent of the other. The register is written whole when `cks_we` is high, reads back on `cks_o`, and is 0 after reset.
- R2: `tx_ready` is high only while the transmitter is idle, and a byte is taken on a cycle with `tx_valid` and `tx_ready` both high. `txd` is 1 while idle and after reset.
- R3: A frame on the line is start (0), then the data bits LSB first, then a parity bit if `par_en` is 1, then one stop bit (1). In 1x mode the first transmit bit enable after a byte is accepted begins the start bit, and each later enable moves to the next bit. One more enable after the stop bit returns the transmitter to idle.
- R4: The parity bit is the XOR of the data bits when `par_odd` is 0, and its inverse when `par_odd` is 1. This applies to both the generated and the checked parity.
- R5: A receiver in 1x mode that is idle treats a 0 sampled on a receive bit enable as a start bit, and samples each following bit on the next enables. After the stop bit is sampled it pulses `rx_valid` for one cycle, with the byte on `rx_data`.
- R6: `rx_ferr` is high with `rx_valid` when the stop bit was sampled as 0, and is low at all other times.
- R7: `rx_perr` is high with `rx_valid` when `par_en` is 1 and the received parity bit differs from R4. It is low at all other times.
- R8: In oversampled mode a tick comes every DIV system clocks and a bit lasts 16 ticks. The receiver confirms a start bit on its 8th low sample, and samples each later bit 16 ticks after the previous sample.
- R9: A bit enable is produced only on a rising edge of `tx_bclk` or `rx_bclk` as seen by `clk`. Holding the level high advances by exactly one bit.
- R10: `loc_bclk_o` is a square wave with a period of 16*DIV system clocks, derived from the internal divider.
- R11: `ms_chg` pulses one cycle after a change on `tx_bclk` (mask bit 0) or `rx_bclk` (mask bit 1), unless that input's bit in `ms_mask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cks_we | input | 1 | Clock-select register write strobe |
| cks_wdata | input | 8 | Clock-select write value |
| cks_o | output | 8 | Clock-select register contents |
| par_en | input | 1 | Parity bit present in frames |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DATA_W | Transmit byte |
| tx_ready | output | 1 | Transmitter idle and able to take a byte |
| txd | output | 1 | Serial transmit line |
| tx_bclk | input | 1 | External transmit 1x bit clock (level) |
| rx_bclk | input | 1 | External receive 1x bit clock (level) |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-cycle pulse marking a received character |
| rx_data | output | DATA_W | Received byte |
| rx_ferr | output | 1 | Stop bit was low (with rx_valid) |
| rx_perr | output | 1 | Parity mismatch (with rx_valid) |
| loc_bclk_o | output | 1 | Local bit-rate clock for the remote end |
| ms_mask | input | 2 | Change-detect mask: bit 0 tx_bclk, bit 1 rx_bclk |
| ms_chg | output | 1 | Unmasked change pulse on a bit-clock input |

## Verification
The bench builds the block with DATA_W = 8 and DIV = 2. A tick every two cycles keeps a full oversampled character to a few hundred cycles, so an oversampled loopback frame, with its start confirmation and mid-bit sampling, fits next to the 1x tests. It also lets the local clock period of 32 cycles be measured directly. In the 1x tests the bench joins `txd` to `rxd` and drives both bit clocks from one source, so the receiver lags the transmitter by one bit. It also drives `rxd` by hand to build framing and parity faults.

// File: rtl/iso_uart_pkg.sv
package iso_uart_pkg;

    // Positions in the clock-select register that pick 1x mode
    localparam int CKS_TX_ISO = 7;
    localparam int CKS_RX_ISO = 3;
    localparam int OVS        = 16;  // ticks per bit when oversampling

    typedef enum logic [2:0] {
        TX_IDLE, TX_PEND, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_HUNT, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
    } frame_cfg_t;

    function automatic logic parity_of(input logic red, input logic odd);
        return red ^ odd;
    endfunction

endpackage

// File: rtl/iso_uart_tick.sv
module iso_uart_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick16,
    output logic bit16,
    output logic loc_clk
);
    import iso_uart_pkg::*;

    localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int SCW = $clog2(OVS);

    logic [DCW-1:0] dcnt;
    logic [SCW-1:0] scnt;

    assign tick16  = (dcnt == DCW'(DIV - 1));
    assign bit16   = tick16 && (scnt == SCW'(OVS - 1));
    assign loc_clk = scnt[SCW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt <= '0;
            scnt <= '0;
        end else if (tick16) begin
            dcnt <= '0;
            scnt <= scnt + 1'b1;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end
endmodule

// File: rtl/iso_uart_tx.sv
module iso_uart_tx #(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_en,
    input  iso_uart_pkg::frame_cfg_t cfg,
    input  logic                    valid,
    input  logic [DATA_W-1:0]       data,
    output logic                    ready,
    output logic                    txd
);
    import iso_uart_pkg::*;

    localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         st;
    logic [DATA_W-1:0] sh;
    logic [BCW-1:0]    bcnt;
    logic              pb;

    assign ready = (st == TX_IDLE);

    always_comb begin
        case (st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_PAR:   txd = pb;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TX_IDLE;
            sh   <= '0;
            bcnt <= '0;
            pb   <= 1'b0;
        end else begin
            case (st)
                TX_IDLE: if (valid) begin
                    sh <= data;
                    pb <= parity_of(^data, cfg.par_odd);
                    st <= TX_PEND;
                end
                TX_PEND:  if (bit_en) st <= TX_START;
                TX_START: if (bit_en) begin
                    st   <= TX_DATA;
                    bcnt <= '0;
                end
                TX_DATA: if (bit_en) begin
                    sh   <= sh >> 1;
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == BCW'(DATA_W - 1))
                        st <= cfg.par_en ? TX_PAR : TX_STOP;
                end
                TX_PAR:  if (bit_en) st <= TX_STOP;
                TX_STOP: if (bit_en) st <= TX_IDLE;
                default: st <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/iso_uart_rx.sv
module iso_uart_rx #(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    iso,
    input  logic                    rise,
    input  logic                    tick,
    input  iso_uart_pkg::frame_cfg_t cfg,
    input  logic                    rxd,
    output logic                    valid,
    output logic [DATA_W-1:0]       data,
    output logic                    ferr,
    output logic                    perr
);
    import iso_uart_pkg::*;

    localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int PCW = $clog2(OVS);

    rx_state_e         st;
    logic [DATA_W-1:0] sh;
    logic [BCW-1:0]    bcnt;
    logic [PCW-1:0]    ph;
    logic              rp;
    logic              samp;

    assign samp = iso ? rise : (tick && (ph == PCW'(OVS - 1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            sh    <= '0;
            bcnt  <= '0;
            ph    <= '0;
            rp    <= 1'b0;
            valid <= 1'b0;
            data  <= '0;
            ferr  <= 1'b0;
            perr  <= 1'b0;
        end else begin
            valid <= 1'b0;
            ferr  <= 1'b0;
            perr  <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (iso) begin
                        if (rise && !rxd) begin
                            st   <= RX_DATA;
                            bcnt <= '0;
                        end
                    end else if (tick && !rxd) begin
                        st <= RX_HUNT;
                        ph <= PCW'(1);
                    end
                end
                RX_HUNT: if (tick) begin
                    if (ph == PCW'(OVS / 2 - 1)) begin
                        if (!rxd) begin
                            st   <= RX_DATA;
                            ph   <= '0;
                            bcnt <= '0;
                        end else begin
                            st <= RX_IDLE;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (tick) ph <= ph + 1'b1;
                    if (samp) begin
                        sh   <= {rxd, sh[DATA_W-1:1]};
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == BCW'(DATA_W - 1))
                            st <= cfg.par_en ? RX_PAR : RX_STOP;
                    end
                end
                RX_PAR: begin
                    if (tick) ph <= ph + 1'b1;
                    if (samp) begin
                        rp <= rxd;
                        st <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (tick) ph <= ph + 1'b1;
                    if (samp) begin
                        valid <= 1'b1;
                        data  <= sh;
                        ferr  <= !rxd;
                        perr  <= cfg.par_en && (rp != parity_of(^sh, cfg.par_odd));
                        st    <= RX_IDLE;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/iso_uart_core.sv
module iso_uart_core #(
    parameter int DATA_W = 8,
    parameter int DIV    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cks_we,
    input  logic [7:0]        cks_wdata,
    output logic [7:0]        cks_o,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              txd,
    input  logic              tx_bclk,
    input  logic              rx_bclk,
    input  logic              rxd,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ferr,
    output logic              rx_perr,
    output logic              loc_bclk_o,
    input  logic [1:0]        ms_mask,
    output logic              ms_chg
);
    import iso_uart_pkg::*;

    logic [7:0] cks_q;
    logic       tx_bclk_q, rx_bclk_q;
    logic       tx_rise, rx_rise;
    logic       tick16, bit16;
    logic       tx_en;
    logic       ms_q;
    frame_cfg_t cfg;

    assign cfg     = '{par_en: par_en, par_odd: par_odd};
    assign cks_o   = cks_q;
    assign tx_rise = tx_bclk && !tx_bclk_q;
    assign rx_rise = rx_bclk && !rx_bclk_q;
    assign tx_en   = cks_q[CKS_TX_ISO] ? tx_rise : bit16;
    assign ms_chg  = ms_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cks_q     <= '0;
            tx_bclk_q <= 1'b0;
            rx_bclk_q <= 1'b0;
            ms_q      <= 1'b0;
        end else begin
            if (cks_we) cks_q <= cks_wdata;
            tx_bclk_q <= tx_bclk;
            rx_bclk_q <= rx_bclk;
            ms_q      <= |(({rx_bclk, tx_bclk} ^ {rx_bclk_q, tx_bclk_q}) & ~ms_mask);
        end
    end

    iso_uart_tick #(.DIV(DIV)) tick_i (
        .clk     (clk),
        .rst     (rst),
        .tick16  (tick16),
        .bit16   (bit16),
        .loc_clk (loc_bclk_o)
    );

    iso_uart_tx #(.DATA_W(DATA_W)) tx_i (
        .clk    (clk),
        .rst    (rst),
        .bit_en (tx_en),
        .cfg    (cfg),
        .valid  (tx_valid),
        .data   (tx_data),
        .ready  (tx_ready),
        .txd    (txd)
    );

    iso_uart_rx #(.DATA_W(DATA_W)) rx_i (
        .clk   (clk),
        .rst   (rst),
        .iso   (cks_q[CKS_RX_ISO]),
        .rise  (rx_rise),
        .tick  (tick16),
        .cfg   (cfg),
        .rxd   (rxd),
        .valid (rx_valid),
        .data  (rx_data),
        .ferr  (rx_ferr),
        .perr  (rx_perr)
    );
endmodule

// File: rtl/iso_uart_chk.sv
module iso_uart_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cks_o,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       txd,
    input logic       rx_valid,
    input logic       rx_ferr,
    input logic       rx_perr,
    input logic       par_en,
    input logic [1:0] ms_mask,
    input logic       ms_chg
);
    p_cks_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cks_o == 8'h00));

    p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_ferr_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
        rx_ferr |-> rx_valid);

    p_perr_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
        rx_perr |-> (rx_valid && par_en));

    p_masked_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        ((ms_mask == 2'b11) && ($past(ms_mask) == 2'b11)) |-> !ms_chg);
endmodule

bind iso_uart_core iso_uart_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .cks_o    (cks_o),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd),
    .rx_valid (rx_valid),
    .rx_ferr  (rx_ferr),
    .rx_perr  (rx_perr),
    .par_en   (par_en),
    .ms_mask  (ms_mask),
    .ms_chg   (ms_chg)
);

// File: tb/iso_uart_core_tb_top.sv
`timescale 1ns/1ps
module iso_uart_core_tb_top;
    localparam int DW  = 8;
    localparam int DIV = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cks_we = 1'b0;
    logic [7:0]    cks_wdata = 8'h00;
    logic [7:0]    cks_o;
    logic          par_en = 1'b0, par_odd = 1'b0;
    logic          tx_valid = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          tx_ready, txd;
    logic          txb = 1'b0, rxb = 1'b0;
    logic          use_man = 1'b0, man_rxd = 1'b1;
    logic          rxd_w;
    logic          rx_valid, rx_ferr, rx_perr;
    logic [DW-1:0] rx_data;
    logic          loc_bclk;
    logic [1:0]    ms_mask = 2'b11;
    logic          ms_chg;

    int nchk = 0, nfail = 0;
    int cyc = 0;
    int rx_cnt = 0, ms_cnt = 0;
    logic [DW-1:0] got_data;
    logic got_ferr, got_perr;
    int loc_last = 0, loc_prev = 0;
    logic loc_d = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign rxd_w = use_man ? man_rxd : txd;

    iso_uart_core #(.DATA_W(DW), .DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .cks_we(cks_we), .cks_wdata(cks_wdata), .cks_o(cks_o),
        .par_en(par_en), .par_odd(par_odd), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .txd(txd), .tx_bclk(txb), .rx_bclk(rxb), .rxd(rxd_w),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
        .loc_bclk_o(loc_bclk), .ms_mask(ms_mask), .ms_chg(ms_chg)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst && rx_valid) begin
            rx_cnt   <= rx_cnt + 1;
            got_data <= rx_data;
            got_ferr <= rx_ferr;
            got_perr <= rx_perr;
        end
        if (!rst && ms_chg) ms_cnt <= ms_cnt + 1;
        loc_d <= loc_bclk;
        if (!rst && loc_bclk && !loc_d) begin
            loc_prev <= loc_last;
            loc_last <= cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cks(input logic [7:0] v);
        @(negedge clk); cks_we = 1'b1; cks_wdata = v;
        @(negedge clk); cks_we = 1'b0;
    endtask

    task automatic send(input logic [DW-1:0] d);
        @(negedge clk); tx_valid = 1'b1; tx_data = d;
        @(negedge clk); tx_valid = 1'b0;
    endtask

    task automatic pulse_both();
        @(negedge clk); txb = 1'b1; rxb = 1'b1;
        @(negedge clk); txb = 1'b0; rxb = 1'b0;
        @(negedge clk);
    endtask

    task automatic make_frame(input logic [DW-1:0] d, input logic pe, input logic po,
                              output logic [11:0] f, output int n);
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < DW; i++) f[1+i] = d[i];
        n = DW + 1;
        if (pe) begin f[n] = (^d) ^ po; n++; end
        f[n] = 1'b1;
        n++;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cks_o == 8'h00, "R1 reset cks", cks_o, 0);
        chk(tx_ready && txd, "R2 reset idle line", {tx_ready, txd}, 3);
        chk(!rx_valid, "R5 reset rx_valid", rx_valid, 0);
    endtask

    task automatic t_iso_loop(input logic [DW-1:0] d, input logic pe, input logic po);
        logic [11:0] f; int n; int mism; int c0; logic pbit;
        set_cks(8'h88);
        use_man = 1'b0; par_en = pe; par_odd = po;
        make_frame(d, pe, po, f, n);
        c0 = rx_cnt; mism = 0; pbit = 1'b0;
        send(d);
        for (int k = 0; k < n; k++) begin
            pulse_both();
            if (txd !== f[k]) mism++;
            if (pe && k == DW + 1) pbit = txd;
        end
        chk(mism == 0, "R3 1x bit sequence", mism, 0);
        if (pe) chk(pbit == ((^d) ^ po), "R4 parity bit", pbit, (^d) ^ po);
        pulse_both();
        chk(tx_ready == 1'b1, "R2 ready after stop", tx_ready, 1);
        @(negedge clk);
        chk(rx_cnt == c0 + 1 && got_data == d && !got_ferr && !got_perr,
            "R5 1x loopback byte", got_data, d);
    endtask

    task automatic t_rx_manual(input logic [DW-1:0] d, input logic pe, input logic po,
                               input bit bad_stop, input bit bad_par);
        logic [11:0] f; int n; int c0;
        set_cks(8'h08);
        use_man = 1'b1; par_en = pe; par_odd = po;
        make_frame(d, pe, po, f, n);
        if (bad_stop) f[n-1] = 1'b0;
        if (bad_par)  f[DW+1] = ~f[DW+1];
        c0 = rx_cnt;
        for (int k = 0; k < n; k++) begin
            @(negedge clk); man_rxd = f[k]; rxb = 1'b1;
            @(negedge clk); rxb = 1'b0;
        end
        @(negedge clk); man_rxd = 1'b1;
        @(negedge clk);
        chk(rx_cnt == c0 + 1 && got_data == d, "R5 manual 1x byte", got_data, d);
        chk(got_ferr == bad_stop, "R6 framing flag", got_ferr, bad_stop);
        chk(got_perr == bad_par, "R7 parity flag", got_perr, bad_par);
    endtask

    task automatic t_hold_level();
        set_cks(8'h80);
        use_man = 1'b1; man_rxd = 1'b1; par_en = 1'b0;
        send(8'hA5);
        @(negedge clk); txb = 1'b1;
        repeat (10) @(negedge clk);
        chk(txd == 1'b0, "R9 held high gives start only", txd, 0);
        txb = 1'b0;
        repeat (3) @(negedge clk);
        txb = 1'b1;
        repeat (10) @(negedge clk);
        chk(txd == 1'b1, "R9 second edge gives D0", txd, 1);
        txb = 1'b0;
        for (int k = 0; k < 9; k++) pulse_both();
        chk(tx_ready == 1'b1, "R9 frame finishes", tx_ready, 1);
    endtask

    task automatic t_ovs_loop();
        int c0; int t0; int el;
        set_cks(8'h00);
        use_man = 1'b0; txb = 1'b0; rxb = 1'b0; par_en = 1'b1; par_odd = 1'b1;
        c0 = rx_cnt;
        send(8'h3C);
        t0 = cyc;
        for (int i = 0; i < 3000 && rx_cnt == c0; i++) @(negedge clk);
        el = cyc - t0;
        chk(rx_cnt == c0 + 1 && got_data == 8'h3C && !got_ferr && !got_perr,
            "R8 oversampled loopback", got_data, 8'h3C);
        chk(el >= 10 * 16 * DIV && el <= 12 * 16 * DIV + 16 * DIV,
            "R8 frame duration", el, 11 * 16 * DIV);
        for (int i = 0; i < 200 && !tx_ready; i++) @(negedge clk);
    endtask

    task automatic t_indep();
        set_cks(8'h08);
        use_man = 1'b1; man_rxd = 1'b1; par_en = 1'b0;
        send(8'h11);
        for (int k = 0; k < 15; k++) pulse_both();
        chk(tx_ready == 1'b0, "R1 tx ignores bit clock when bit7 clear", tx_ready, 0);
        for (int i = 0; i < 1000 && !tx_ready; i++) @(negedge clk);
        chk(tx_ready == 1'b1, "R1 tx completes oversampled", tx_ready, 1);
        set_cks(8'h80);
        send(8'h22);
        for (int k = 0; k < 11; k++) pulse_both();
        chk(tx_ready == 1'b1, "R1 tx follows bit clock when bit7 set", tx_ready, 1);
        chk(cks_o == 8'h80, "R1 readback", cks_o, 8'h80);
    endtask

    task automatic t_locclk();
        repeat (4 * 16 * DIV) @(negedge clk);
        chk(loc_last - loc_prev == 16 * DIV, "R10 local clock period",
            loc_last - loc_prev, 16 * DIV);
    endtask

    task automatic t_ms();
        int c0;
        use_man = 1'b1; man_rxd = 1'b1;
        @(negedge clk); ms_mask = 2'b00;
        repeat (2) @(negedge clk);
        c0 = ms_cnt;
        repeat (3) begin
            @(negedge clk); rxb = 1'b1;
            @(negedge clk); rxb = 1'b0;
        end
        repeat (2) @(negedge clk);
        chk(ms_cnt == c0 + 6, "R11 unmasked changes", ms_cnt - c0, 6);
        @(negedge clk); ms_mask = 2'b10;
        repeat (2) @(negedge clk);
        c0 = ms_cnt;
        repeat (3) begin
            @(negedge clk); rxb = 1'b1;
            @(negedge clk); rxb = 1'b0;
        end
        repeat (2) @(negedge clk);
        chk(ms_cnt == c0, "R11 masked rx clock", ms_cnt - c0, 0);
        @(negedge clk); txb = 1'b1;
        @(negedge clk); txb = 1'b0;
        repeat (2) @(negedge clk);
        chk(ms_cnt == c0 + 2, "R11 tx clock still seen", ms_cnt - c0, 2);
        @(negedge clk); ms_mask = 2'b11;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_iso_loop(8'hA5, 1'b0, 1'b0);
        t_iso_loop(8'h6B, 1'b1, 1'b0);
        t_iso_loop(8'h01, 1'b1, 1'b1);
        t_rx_manual(8'hC3, 1'b0, 1'b0, 1'b1, 1'b0);
        t_rx_manual(8'h5A, 1'b1, 1'b1, 1'b0, 1'b1);
        t_rx_manual(8'h7E, 1'b1, 1'b0, 1'b0, 1'b0);
        t_hold_level();
        t_ovs_loop();
        t_indep();
        t_locclk();
        t_ms();
        finish_run();
    end
endmodule